// File: doc/BRIEF.md
# Metaframe Frame Synchronizer

This block sits behind the word-lock stage of one serial lane. It takes 66-bit words that have already been aligned and had their inversion bit removed. It sorts each word into the framing-layer control types (synchronization, scrambler state, skip, diagnostic) and follows the metaframe structure. A frame lock state machine searches for synchronization words at the programmed metaframe spacing. Once the block holds lock, it checks every metaframe for the synchronization word and for a scrambler state word that agrees with the state the local descrambler predicts.

The metaframe length is an input, set between 5 and 8191 words. It must match the length the transmitter uses. The outputs are the lock status, a one-cycle marker on each accepted metaframe start, one flag per control-word type, and the received scrambler state together with its strobe. The descrambler uses the received state to reseed. Every output is registered, so each one shows the result for the word that was presented with `inValid` high one clock earlier.

Top module: `metaframe_aligner`

## Requirements
- R1: A word is a synchronization word when its header `inWord[65:64]` is 2'b10 and its payload `inWord[63:0]` equals SYNC_PATTERN (default 64'h78F678F678F678F6). The same payload under any other header is not one. `isSync` reports it on the next cycle.
- R2: For a control word (header 2'b10) other than sync, payload bits [63:58] give its type: 6'b001010 means scrambler state (`isScram`), 6'b000111 means skip (`isSkip`), 6'b011001 means diagnostic (`isDiag`). All flags are low on the cycle after a word with `inValid` low.
- R3: Frame lock rises on the fourth consecutive synchronization word in which each one follows the previous one by exactly `mfLen` valid words.
- R4: `sofMark` pulses for a sync word seen while hunting, or for a sync word found at the expected metaframe-start slot. A sync word at any other position while verifying or locked is ignored and gives no pulse.
- R5: While locked, four consecutive metaframes without a sync word at the start slot drop lock. The drop happens on the fourth missing word. A sync word that arrives clears the miss count.
- R6: While locked, the word right after the start slot must be a scrambler state word whose bits [57:0] equal `expState`. Three consecutive failures of this check drop lock on the third one, and a match clears the count.
- R7: While verifying a candidate, a missing sync word at the expected slot abandons the candidate and zeroes the sync count. Hunting resumes on the next sync word.
- R8: A synchronous reset `rst` clears the lock state, the position and all counters. `frameLock` is low after reset.
- R9: For every scrambler state word, `rxState` takes on payload bits [57:0] and `rxStateValid` pulses for one cycle. At all other times `rxState` holds.
- R10: A word presented with `inValid` low is not counted and does not advance the metaframe position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies inWord |
| inWord | input | 66 | Header [65:64] and payload [63:0] |
| mfLen | input | 13 | Metaframe length in words (5 to 8191) |
| expState | input | 58 | Scrambler state predicted by the local descrambler |
| frameLock | output | 1 | Metaframe lock status |
| sofMark | output | 1 | Accepted metaframe start |
| isSync | output | 1 | Word was a synchronization word |
| isScram | output | 1 | Word was a scrambler state word |
| isSkip | output | 1 | Word was a skip word |
| isDiag | output | 1 | Word was a diagnostic word |
| rxState | output | 58 | Last received scrambler state |
| rxStateValid | output | 1 | rxState updated this cycle |

## Verification
The bench drives well-formed metaframes so that lock forms on the fourth sync. The patterns are built so that each decision depends on one fault:
- Sync-miss runs of three and of four separate the reset of the miss count from the loss of lock.
- Mismatch runs of two and of three do the same for the scrambler state check.
- A candidate that fails after two syncs shows that the count restarts from zero and does not carry over.
- Idle gaps in the middle of a frame, and sync payloads under a data header, show that neither one is counted.
- With the length set to 8, the 8-word frames lock. Frames of 5 words never lock, and their sof pattern alternates, which shows that misplaced syncs are ignored.

// File: rtl/mfs_pkg.sv
package mfs_pkg;
  localparam int PAYLOAD_W = 64;
  localparam int HDR_W     = 2;
  localparam int WORD_W    = PAYLOAD_W + HDR_W;
  localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

  // classification handed from datapath to control
  typedef struct packed {
    logic sync;
    logic stateHit;   // scrambler state word carrying the predicted state
  } wordClass_t;

  // strobes from control back into the datapath
  typedef struct packed {
    logic sofHit;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {ST_HUNT, ST_VERIFY, ST_LOCKED} lockState_t;
endpackage

// File: rtl/mfs_datapath.sv
module mfs_datapath
  import mfs_pkg::*;
#(
  parameter logic [63:0] SYNC_PATTERN = 64'h78F678F678F678F6,
  parameter int          STATE_W      = 58,
  parameter logic [PAYLOAD_W-STATE_W-1:0] SCRAM_CODE = 6'b001010,
  parameter logic [PAYLOAD_W-STATE_W-1:0] SKIP_CODE  = 6'b000111,
  parameter logic [PAYLOAD_W-STATE_W-1:0] DIAG_CODE  = 6'b011001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [WORD_W-1:0]  inWord,
  input  logic [STATE_W-1:0] expState,
  input  ctrlStrobe_t        strobe,
  output wordClass_t         cls,
  output logic               sofMark,
  output logic               isSync,
  output logic               isScram,
  output logic               isSkip,
  output logic               isDiag,
  output logic [STATE_W-1:0] rxState,
  output logic               rxStateValid
);
  localparam int CODE_W = PAYLOAD_W - STATE_W;

  logic [PAYLOAD_W-1:0] payload;
  logic [CODE_W-1:0]    typeCode;
  logic                 ctrlHdr;
  logic                 syncHit;
  logic                 scramHit;
  logic                 skipHit;
  logic                 diagHit;

  assign payload  = inWord[PAYLOAD_W-1:0];
  assign typeCode = payload[PAYLOAD_W-1:STATE_W];
  assign ctrlHdr  = inWord[WORD_W-1:PAYLOAD_W] == HDR_CTRL;
  assign syncHit  = ctrlHdr && (payload == SYNC_PATTERN);
  assign scramHit = ctrlHdr && !syncHit && (typeCode == SCRAM_CODE);
  assign skipHit  = ctrlHdr && !syncHit && (typeCode == SKIP_CODE);
  assign diagHit  = ctrlHdr && !syncHit && (typeCode == DIAG_CODE);

  assign cls.sync     = syncHit;
  assign cls.stateHit = scramHit && (payload[STATE_W-1:0] == expState);

  always_ff @(posedge clk) begin
    if (rst) begin
      sofMark      <= 1'b0;
      isSync       <= 1'b0;
      isScram      <= 1'b0;
      isSkip       <= 1'b0;
      isDiag       <= 1'b0;
      rxStateValid <= 1'b0;
      rxState      <= '0;
    end else begin
      sofMark      <= strobe.sofHit;
      isSync       <= inValid && syncHit;
      isScram      <= inValid && scramHit;
      isSkip       <= inValid && skipHit;
      isDiag       <= inValid && diagHit;
      rxStateValid <= inValid && scramHit;
      if (inValid && scramHit) rxState <= payload[STATE_W-1:0];
    end
  end

  AST_IDLE_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !(isSync || isScram || isSkip || isDiag)); // R2
  AST_SOF_IS_SYNC: assert property (@(posedge clk) disable iff (rst)
    sofMark |-> isSync); // R4
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rxStateValid |-> $stable(rxState)); // R9
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({isSync, isScram, isSkip, isDiag})); // R1
endmodule

// File: rtl/mfs_control.sv
module mfs_control
  import mfs_pkg::*;
#(
  parameter int MF_LEN_W   = 13,
  parameter int LOCK_SYNCS = 4,
  parameter int SYNC_LOSS  = 4,
  parameter int SCRAM_LOSS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [MF_LEN_W-1:0] mfLen,
  input  wordClass_t          cls,
  output ctrlStrobe_t         strobe,
  output logic                frameLock
);
  localparam int GOOD_W = $clog2(LOCK_SYNCS + 1);
  localparam int BADS_W = $clog2(SYNC_LOSS + 1);
  localparam int BADX_W = $clog2(SCRAM_LOSS + 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST  = GOOD_W'(LOCK_SYNCS - 1);
  localparam logic [BADS_W-1:0] SYNC_LAST  = BADS_W'(SYNC_LOSS - 1);
  localparam logic [BADX_W-1:0] SCRAM_LAST = BADX_W'(SCRAM_LOSS - 1);

  lockState_t          state;
  logic [MF_LEN_W-1:0] pos;
  logic [MF_LEN_W-1:0] posNext;
  logic [GOOD_W-1:0]   goodCnt;
  logic [BADS_W-1:0]   badSync;
  logic [BADX_W-1:0]   badScram;
  logic                atSyncSlot;
  logic                atScramSlot;

  assign atSyncSlot  = pos == '0;
  assign atScramSlot = pos == MF_LEN_W'(1);
  assign posNext     = (pos == mfLen - 1'b1) ? '0 : pos + 1'b1;
  assign frameLock   = state == ST_LOCKED;
  assign strobe.sofHit = inValid && cls.sync && (state == ST_HUNT || atSyncSlot);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HUNT;
      pos      <= '0;
      goodCnt  <= '0;
      badSync  <= '0;
      badScram <= '0;
    end else if (inValid) begin
      unique case (state)
        ST_HUNT: begin
          if (cls.sync) begin
            state   <= ST_VERIFY;
            pos     <= MF_LEN_W'(1);
            goodCnt <= GOOD_W'(1);
          end
        end
        ST_VERIFY: begin
          pos <= posNext;
          if (atSyncSlot) begin
            if (!cls.sync) begin
              state   <= ST_HUNT;
              goodCnt <= '0;
            end else if (goodCnt == GOOD_LAST) begin
              state    <= ST_LOCKED;
              goodCnt  <= '0;
              badSync  <= '0;
              badScram <= '0;
            end else begin
              goodCnt <= goodCnt + 1'b1;
            end
          end
        end
        default: begin
          pos <= posNext;
          if (atSyncSlot) begin
            if (cls.sync) begin
              badSync <= '0;
            end else if (badSync == SYNC_LAST) begin
              state   <= ST_HUNT;
              badSync <= '0;
              badScram <= '0;
            end else begin
              badSync <= badSync + 1'b1;
            end
          end
          if (atScramSlot) begin
            if (cls.stateHit) begin
              badScram <= '0;
            end else if (badScram == SCRAM_LAST) begin
              state    <= ST_HUNT;
              badSync  <= '0;
              badScram <= '0;
            end else begin
              badScram <= badScram + 1'b1;
            end
          end
        end
      endcase
    end
  end

  AST_LOCK_NEEDS_SYNC: assert property (@(posedge clk) disable iff (rst)
    $rose(frameLock) |-> $past(inValid && cls.sync)); // R3
  AST_SYNC_MISS_BOUND: assert property (@(posedge clk) disable iff (rst)
    badSync <= SYNC_LAST); // R5
  AST_SCRAM_MISS_BOUND: assert property (@(posedge clk) disable iff (rst)
    badScram <= SCRAM_LAST); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (state == ST_HUNT && goodCnt == '0 && badSync == '0 && badScram == '0)); // R8
  AST_POS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(pos) && $stable(state)); // R10
endmodule

// File: rtl/metaframe_aligner.sv
module metaframe_aligner
  import mfs_pkg::*;
#(
  parameter int          MF_LEN_W     = 13,
  parameter int          STATE_W      = 58,
  parameter logic [63:0] SYNC_PATTERN = 64'h78F678F678F678F6,
  parameter int          LOCK_SYNCS   = 4,
  parameter int          SYNC_LOSS    = 4,
  parameter int          SCRAM_LOSS   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [WORD_W-1:0]   inWord,
  input  logic [MF_LEN_W-1:0] mfLen,
  input  logic [STATE_W-1:0]  expState,
  output logic                frameLock,
  output logic                sofMark,
  output logic                isSync,
  output logic                isScram,
  output logic                isSkip,
  output logic                isDiag,
  output logic [STATE_W-1:0]  rxState,
  output logic                rxStateValid
);
  wordClass_t  wordCls;
  ctrlStrobe_t ctrlStb;

  mfs_datapath #(
    .SYNC_PATTERN(SYNC_PATTERN),
    .STATE_W     (STATE_W)
  ) i_datapath (
    .clk         (clk),
    .rst         (rst),
    .inValid     (inValid),
    .inWord      (inWord),
    .expState    (expState),
    .strobe      (ctrlStb),
    .cls         (wordCls),
    .sofMark     (sofMark),
    .isSync      (isSync),
    .isScram     (isScram),
    .isSkip      (isSkip),
    .isDiag      (isDiag),
    .rxState     (rxState),
    .rxStateValid(rxStateValid)
  );

  mfs_control #(
    .MF_LEN_W  (MF_LEN_W),
    .LOCK_SYNCS(LOCK_SYNCS),
    .SYNC_LOSS (SYNC_LOSS),
    .SCRAM_LOSS(SCRAM_LOSS)
  ) i_control (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .mfLen    (mfLen),
    .cls      (wordCls),
    .strobe   (ctrlStb),
    .frameLock(frameLock)
  );

  AST_LOCK_STARTS_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(frameLock) |-> sofMark); // R3
endmodule

// File: tb/test_metaframe_aligner.sv
module test_metaframe_aligner;
  localparam logic [63:0] SYNCP = 64'h78F678F678F678F6;
  localparam logic [57:0] EXPST = 58'h0AB_CDEF_1234_5678;
  localparam logic [5:0]  C_SCR = 6'b001010;
  localparam logic [5:0]  C_SKP = 6'b000111;
  localparam logic [5:0]  C_DIA = 6'b011001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [65:0] inWord = '0;
  logic [12:0] mfLen = 13'd5;
  logic [57:0] expState = EXPST;
  logic        frameLock, sofMark, isSync, isScram, isSkip, isDiag, rxStateValid;
  logic [57:0] rxState;

  always #4 clk = ~clk;

  metaframe_aligner i_metaframe_aligner (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord), .mfLen(mfLen),
    .expState(expState), .frameLock(frameLock), .sofMark(sofMark), .isSync(isSync),
    .isScram(isScram), .isSkip(isSkip), .isDiag(isDiag), .rxState(rxState),
    .rxStateValid(rxStateValid)
  );

  typedef struct {
    bit          lock;
    bit          sof;
    bit [3:0]    flags;   // {sync, scram, skip, diag}
    bit          chkState;
    logic [57:0] st;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  function automatic logic [65:0] ctrlW(input logic [63:0] p);
    return {2'b10, p};
  endfunction

  // driver: presents one word and queues what must appear one cycle later
  task automatic put(input logic v, input logic [65:0] w, input bit lk, input bit sf,
                     input bit [3:0] fl, input bit cs, input logic [57:0] st, input string rq);
    exp_t e;
    @(negedge clk);
    inValid = v;
    inWord  = w;
    e.lock = lk; e.sof = sf; e.flags = fl; e.chkState = cs; e.st = st; e.req = rq;
    q.push_back(e);
  endtask

  task automatic quiet();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic frame(input int len, input bit syncOk, input bit scramOk, input bit sofE,
                       input bit lkSync, input bit lkAfter, input string rq);
    logic [57:0] st;
    st = scramOk ? EXPST : (EXPST ^ 58'h1);
    if (syncOk) put(1'b1, ctrlW(SYNCP), lkSync, sofE, 4'b1000, 1'b0, '0, rq);
    else        put(1'b1, {2'b01, 64'h0123_4567_89AB_CDEF}, lkSync, 1'b0, 4'b0000, 1'b0, '0, rq);
    put(1'b1, ctrlW({C_SCR, st}), lkAfter, 1'b0, 4'b0100, 1'b1, st, rq);
    for (int i = 2; i < len; i++) begin
      if (i == 3)      put(1'b1, ctrlW({C_SKP, 58'h0}), lkAfter, 1'b0, 4'b0010, 1'b0, '0, rq);
      else if (i == 4) put(1'b1, ctrlW({C_DIA, 58'h1}), lkAfter, 1'b0, 4'b0001, 1'b0, '0, rq);
      else             put(1'b1, {2'b01, 64'hFEED_0000_0000_0000 | 64'(i)}, lkAfter, 1'b0, 4'b0000, 1'b0, '0, rq);
    end
  endtask

  task automatic doReset(input logic [12:0] len);
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    mfLen = len;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic checkNow(input bit cond, input string rq, input string what, input int act, input int expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  // monitor: compares the registered outputs one edge after each queued word
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        bit ok;
        e = q.pop_front();
        ok = (frameLock == e.lock) && (sofMark == e.sof) &&
             ({isSync, isScram, isSkip, isDiag} == e.flags) &&
             (!e.chkState || (rxStateValid && rxState == e.st)) &&
             (e.chkState || !rxStateValid);
        checks++;
        if (!ok) begin
          fails++;
          $display("FAIL %s lock/sof/flags/stv actual=%0b/%0b/%04b/%0b st=%h expected=%0b/%0b/%04b/%0b st=%h",
                   e.req, frameLock, sofMark, {isSync, isScram, isSkip, isDiag}, rxStateValid, rxState,
                   e.lock, e.sof, e.flags, e.chkState, e.st);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset(13'd5);
    @(negedge clk);
    // R8: reset state
    checkNow(frameLock == 1'b0, "R8", "frameLock after reset", int'(frameLock), 0);
    checkNow({sofMark, isSync, isScram, isSkip, isDiag, rxStateValid} == 6'b0, "R8", "flags after reset",
             int'({sofMark, isSync, isScram, isSkip, isDiag, rxStateValid}), 0);

    // R1: sync payload under a data header is not a sync word
    put(1'b1, {2'b01, SYNCP}, 1'b0, 1'b0, 4'b0000, 1'b0, '0, "R1");
    put(1'b1, {2'b11, SYNCP}, 1'b0, 1'b0, 4'b0000, 1'b0, '0, "R1");
    put(1'b1, {2'b01, 64'h0}, 1'b0, 1'b0, 4'b0000, 1'b0, '0, "R1");

    // R3: acquisition on the fourth spaced sync
    frame(5, 1, 1, 1, 0, 0, "R3");
    frame(5, 1, 1, 1, 0, 0, "R3");
    frame(5, 1, 1, 1, 0, 0, "R3");
    frame(5, 1, 1, 1, 1, 1, "R3");

    // R10: invalid words, even sync-shaped ones, are not counted and freeze position
    frame(5, 1, 1, 1, 1, 1, "R2");
    put(1'b0, ctrlW(SYNCP), 1'b1, 1'b0, 4'b0000, 1'b0, '0, "R10");
    put(1'b0, ctrlW({C_SKP, 58'h0}), 1'b1, 1'b0, 4'b0000, 1'b0, '0, "R10");
    frame(5, 1, 1, 1, 1, 1, "R10");

    // R5: three misses survive, four drop lock
    frame(5, 0, 1, 0, 1, 1, "R5");
    frame(5, 0, 1, 0, 1, 1, "R5");
    frame(5, 0, 1, 0, 1, 1, "R5");
    frame(5, 1, 1, 1, 1, 1, "R5");
    frame(5, 0, 1, 0, 1, 1, "R5");
    frame(5, 0, 1, 0, 1, 1, "R5");
    frame(5, 0, 1, 0, 1, 1, "R5");
    frame(5, 0, 1, 0, 0, 0, "R5");

    // R7: failed candidate restarts the count from zero
    frame(5, 1, 1, 1, 0, 0, "R7");
    frame(5, 1, 1, 1, 0, 0, "R7");
    frame(5, 0, 1, 0, 0, 0, "R7");
    frame(5, 1, 1, 1, 0, 0, "R7");
    frame(5, 1, 1, 1, 0, 0, "R7");
    frame(5, 1, 1, 1, 0, 0, "R7");
    frame(5, 1, 1, 1, 1, 1, "R7");

    // R6 and R9: two mismatches survive, three drop lock; received state reported each time
    frame(5, 1, 0, 1, 1, 1, "R6");
    frame(5, 1, 0, 1, 1, 1, "R6");
    frame(5, 1, 1, 1, 1, 1, "R9");
    frame(5, 1, 0, 1, 1, 1, "R6");
    frame(5, 1, 0, 1, 1, 1, "R6");
    frame(5, 1, 0, 1, 1, 0, "R6");

    // R8: reset while locked
    frame(5, 1, 1, 1, 0, 0, "R3");
    frame(5, 1, 1, 1, 0, 0, "R3");
    frame(5, 1, 1, 1, 0, 0, "R3");
    frame(5, 1, 1, 1, 1, 1, "R3");
    doReset(13'd8);
    @(negedge clk);
    checkNow(frameLock == 1'b0, "R8", "frameLock after reset while locked", int'(frameLock), 0);

    // R3: programmed length 8
    frame(8, 1, 1, 1, 0, 0, "R3");
    frame(8, 1, 1, 1, 0, 0, "R3");
    frame(8, 1, 1, 1, 0, 0, "R3");
    frame(8, 1, 1, 1, 1, 1, "R3");

    // R4: syncs at the wrong spacing never lock and misplaced ones give no marker
    doReset(13'd8);
    frame(5, 1, 1, 1, 0, 0, "R4");
    frame(5, 1, 1, 0, 0, 0, "R4");
    frame(5, 1, 1, 1, 0, 0, "R4");
    frame(5, 1, 1, 0, 0, 0, "R4");
    quiet();

    repeat (3) @(negedge clk);
    checkNow(q.size() == 0, "R2", "pending expectations", q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule